// File: doc/BRIEF.md
# UART line-control transmit framer

This block serializes one parallel character at a time onto a transmit line, the way the transmit side of a classic PC-style serial port does. A line control register sets the character length, the number of stop bits, and the parity mode: parity off, even, odd, or forced to a fixed level. The same register holds a break control that pulls the line to the spacing level, and a bank-select bit that decides whether the two lowest register offsets reach the baud divisor latches or the data and interrupt-enable registers. A receive-side parity checker uses the same settings to judge received characters.

The host writes and reads the control register through a small register port. A per-bit baud tick comes from an external divisor. Characters are offered with a valid/ready pair. Every frame takes its format from the control register value that was current when the character was accepted. A later register write only affects following frames, with one exception: the break control acts on the line at once.

Top module: `uart_lcr_framer`

## Requirements
- R1: The line control register is at offset 3. It is 8 bits wide, readable and writable, and resets to 0x00. Reads at any other offset return 0x00.
- R2: When reg_req_i is high, sel_o decodes the offset using register bit 7. With bit 7 clear, offset 0 gives sel_o=4'b0001 (holding register) and offset 1 gives 4'b0010 (interrupt enable). With bit 7 set, offset 0 gives 4'b0100 (divisor low) and offset 1 gives 4'b1000 (divisor high). Every other case gives 4'b0000.
- R3: The line idles at 1. An accepted character waits for the next baud tick, then sends a 0 start bit. Next come the data bits, LSB first, with the count given by bits 1:0 (00=5, 01=6, 10=7, 11=8). Last come the stop bits at 1: one when bit 2 is 0, two when bit 2 is 1. Each bit begins on a tick and lasts one tick period.
- R4: When bit 3 is 1, one parity bit is sent between the last data bit and the first stop bit. When bit 3 is 0, no parity bit is sent.
- R5: With bit 3 set and bit 5 clear, bit 4 = 1 makes the count of ones in the selected data bits plus parity even. Bit 4 = 0 makes that count odd. Unselected high data bits do not count.
- R6: With bits 3 and 5 set, the parity bit is 0 when bit 4 is 1, and 1 when bit 4 is 0.
- R7: While bit 6 is 1, txd_o is 0. The frame keeps advancing, so clearing bit 6 mid-frame resumes the correct remaining bits.
- R8: A register write during a frame changes the format of the next frame only. The current frame is not affected.
- R9: Each rx_chk_i strobe makes par_err_o high for exactly the next cycle when bit 3 is set and rx_par_i differs from the parity that R5/R6 give for rx_data_i. Otherwise par_err_o stays 0. Parity is never flagged when bit 3 is clear.
- R10: tx_ready_o is 1 only while no frame is pending or in progress. A character is accepted when tx_valid_i and tx_ready_o are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_req_i | input | 1 | Register access strobe |
| reg_wr_i | input | 1 | Write qualifier for the access |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data |
| sel_o | output | 4 | One-hot target select for offsets 0/1 |
| baud_tick_i | input | 1 | One-cycle pulse per bit period |
| tx_valid_i | input | 1 | Character offered |
| tx_data_i | input | 8 | Character to send |
| tx_ready_o | output | 1 | Framer can accept a character |
| txd_o | output | 1 | Serial transmit line |
| rx_chk_i | input | 1 | Strobe: received character ready to check |
| rx_data_i | input | 8 | Received data bits |
| rx_par_i | input | 1 | Received parity bit |
| par_err_o | output | 1 | One-cycle parity error pulse |

## Verification
The hardest situations to reach are a register write that lands in the middle of a frame and a break that is set and then cleared part-way through a character. Both are invisible unless the bench checks every remaining bit of the frame afterwards. The bench controls each baud tick itself, so it can write the register between two chosen bits. It then checks each later bit against the format latched at acceptance, and checks that the following frame picks up the new format. Random characters and register values cover every word length, stop count and parity mode. Directed data words with known ones counts pin down how parity treats the unselected high bits.

// File: rtl/uart_lcr_pkg.sv
package uart_lcr_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = $clog2(DATA_W);
  localparam int MIN_BITS = 5;

  typedef struct packed {
    logic       dlab;
    logic       brk;
    logic       stick;
    logic       even;
    logic       pen;
    logic       stop2;
    logic [1:0] wlen;
  } lcr_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_START, ST_DATA, ST_PAR, ST_STOP
  } tx_st_e;

  function automatic logic calc_par(logic [DATA_W-1:0] d, logic [1:0] wlen,
                                    logic even, logic stick);
    logic x;
    x = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < MIN_BITS + int'(wlen)) x ^= d[i];
    if (stick) return ~even;
    return even ? x : ~x;
  endfunction
endpackage

// File: rtl/uart_lcr_reg.sv
module uart_lcr_reg
  import uart_lcr_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int LCR_OFFS    = 3,
  parameter int LO_OFFS     = 0,
  parameter int HI_OFFS     = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [3:0]        sel_o,
  output lcr_t              lcr_o
);
  localparam logic [ADDR_W-1:0] A_LCR = ADDR_W'(LCR_OFFS);
  localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(LO_OFFS);
  localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(HI_OFFS);

  lcr_t lcr_q;
  logic wr_lcr;

  assign wr_lcr = req_i && wr_i && (addr_i == A_LCR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lcr_q <= '0;
    else if (wr_lcr) lcr_q <= lcr_t'(wdata_i);
  end

  assign rdata_o = (addr_i == A_LCR) ? 8'(lcr_q) : 8'h00;

  always_comb begin
    sel_o = 4'b0000;
    if (req_i) begin
      if (addr_i == A_LO) sel_o = lcr_q.dlab ? 4'b0100 : 4'b0001;
      if (addr_i == A_HI) sel_o = lcr_q.dlab ? 4'b1000 : 4'b0010;
    end
  end

  assign lcr_o = lcr_q;

  a_r1_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lcr |=> (8'(lcr_q) == $past(wdata_i)));
  a_r2_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_lcr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        wlen_i,
  input  logic              stop2_i,
  input  logic              pen_i,
  input  logic              even_i,
  input  logic              stick_i,
  output logic              ready_o,
  output logic              line_o
);
  tx_st_e            state_q;
  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        wlen_q;
  logic              stop2_q, pen_q, par_q;
  logic [CNT_W-1:0]  last_idx;

  assign last_idx = CNT_W'(MIN_BITS - 1) + CNT_W'(wlen_q);
  assign ready_o  = (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      wlen_q  <= '0;
      stop2_q <= 1'b0;
      pen_q   <= 1'b0;
      par_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (valid_i) begin
          // format frozen here for the whole frame
          sh_q    <= data_i;
          wlen_q  <= wlen_i;
          stop2_q <= stop2_i;
          pen_q   <= pen_i;
          par_q   <= calc_par(data_i, wlen_i, even_i, stick_i);
          state_q <= ST_ARM;
        end
        ST_ARM:   if (tick_i) state_q <= ST_START;
        ST_START: if (tick_i) begin
          cnt_q   <= '0;
          state_q <= ST_DATA;
        end
        ST_DATA: if (tick_i) begin
          sh_q <= sh_q >> 1;
          if (cnt_q == last_idx) begin
            cnt_q   <= '0;
            state_q <= pen_q ? ST_PAR : ST_STOP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PAR: if (tick_i) begin
          cnt_q   <= '0;
          state_q <= ST_STOP;
        end
        ST_STOP: if (tick_i) begin
          if (stop2_q && cnt_q == '0) cnt_q <= CNT_W'(1);
          else                        state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = sh_q[0];
      ST_PAR:   line_o = par_q;
      default:  line_o = 1'b1;
    endcase
  end

  a_r3_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && !tick_i) |=> $stable(state_q));
  a_r8_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && $past(state_q) != ST_IDLE)
      |-> $stable({wlen_q, stop2_q, pen_q, par_q}));
  a_r10_ready_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && valid_i) |=> !ready_o);
endmodule

// File: rtl/uart_par_check.sv
module uart_par_check
  import uart_lcr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chk_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  input  logic [1:0]        wlen_i,
  input  logic              pen_i,
  input  logic              even_i,
  input  logic              stick_i,
  output logic              err_o
);
  logic exp_par;
  assign exp_par = calc_par(data_i, wlen_i, even_i, stick_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= chk_i && pen_i && (par_i != exp_par);
  end

  a_r9_err_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($past(chk_i) && $past(pen_i)));
endmodule

// File: rtl/uart_lcr_framer.sv
module uart_lcr_framer
  import uart_lcr_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int LCR_OFFS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic [3:0]        sel_o,
  input  logic              baud_tick_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  output logic              txd_o,
  input  logic              rx_chk_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_par_i,
  output logic              par_err_o
);
  lcr_t lcr;
  logic line;

  uart_lcr_reg #(.ADDR_W(ADDR_W), .LCR_OFFS(LCR_OFFS)) u_reg (
    .clk_i, .rst_ni,
    .req_i(reg_req_i), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .sel_o(sel_o), .lcr_o(lcr)
  );

  uart_tx_framer u_tx (
    .clk_i, .rst_ni,
    .tick_i(baud_tick_i), .valid_i(tx_valid_i), .data_i(tx_data_i),
    .wlen_i(lcr.wlen), .stop2_i(lcr.stop2), .pen_i(lcr.pen),
    .even_i(lcr.even), .stick_i(lcr.stick),
    .ready_o(tx_ready_o), .line_o(line)
  );

  uart_par_check u_chk (
    .clk_i, .rst_ni,
    .chk_i(rx_chk_i), .data_i(rx_data_i), .par_i(rx_par_i),
    .wlen_i(lcr.wlen), .pen_i(lcr.pen), .even_i(lcr.even),
    .stick_i(lcr.stick), .err_o(par_err_o)
  );

  // break masks the pin only; the framer keeps stepping
  assign txd_o = line & ~lcr.brk;
endmodule

// File: tb/uart_lcr_framer_tb.sv
module uart_lcr_framer_tb;
  logic       clk = 0, rst_ni = 0;
  logic       reg_req = 0, reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [3:0] sel;
  logic       tick = 0, tx_valid = 0, tx_ready, txd;
  logic [7:0] tx_data = 0, rx_data = 0;
  logic       rx_chk = 0, rx_par = 0, par_err;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_lcr_framer u_dut (
    .clk_i(clk), .rst_ni, .reg_req_i(reg_req), .reg_wr_i(reg_wr),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .sel_o(sel), .baud_tick_i(tick), .tx_valid_i(tx_valid), .tx_data_i(tx_data),
    .tx_ready_o(tx_ready), .txd_o(txd), .rx_chk_i(rx_chk), .rx_data_i(rx_data),
    .rx_par_i(rx_par), .par_err_o(par_err)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_par(input logic [7:0] d, input logic [7:0] c);
    logic x = 0;
    for (int i = 0; i < 5 + int'(c[1:0]); i++) x ^= d[i];
    if (c[5]) return ~c[4];
    return c[4] ? x : ~x;
  endfunction

  function automatic int flen(input logic [7:0] c);
    return 1 + 5 + int'(c[1:0]) + int'(c[3]) + 1 + int'(c[2]);
  endfunction

  // idx 0 = start bit
  function automatic logic exp_bit(input logic [7:0] d, input logic [7:0] c, input int idx);
    int nb = 5 + int'(c[1:0]);
    if (idx == 0) return 1'b0;
    if (idx <= nb) return d[idx-1];
    if (c[3] && idx == nb + 1) return exp_par(d, c);
    return 1'b1;
  endfunction

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] v);
    @(negedge clk); reg_req = 1; reg_wr = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_req = 0; reg_wr = 0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  // mode 0 normal, 1 break pulse mid-frame, 2 register change mid-frame
  task automatic send(input logic [7:0] d, input logic [7:0] c, input bit do_wr,
                      input int mode, input logic [7:0] alt);
    int n;
    if (do_wr) wr_reg(3'd3, c);
    @(negedge clk); tx_valid = 1; tx_data = d;
    @(negedge clk); tx_valid = 0;
    check("R10 ready drops after accept", {7'd0, tx_ready}, 8'd0);
    check("R3 line idle until tick", {7'd0, txd}, 8'd1);
    n = flen(c);
    for (int idx = 0; idx < n; idx++) begin
      logic e;
      if (mode == 1 && idx == 2) wr_reg(3'd3, c | 8'h40);
      if (mode == 1 && idx == 4) wr_reg(3'd3, c);
      if (mode == 2 && idx == 1) wr_reg(3'd3, alt);
      do_tick();
      e = (mode == 1 && (idx == 2 || idx == 3)) ? 1'b0 : exp_bit(d, c, idx);
      if (mode == 1) check("R7 break then resume", {7'd0, txd}, {7'd0, e});
      else if (mode == 2) check("R8 frame keeps old format", {7'd0, txd}, {7'd0, e});
      else if (c[3] && idx == n - 2 - int'(c[2]))
        check(c[5] ? "R6 stick parity bit" : "R5 parity bit", {7'd0, txd}, {7'd0, e});
      else check("R3/R4 frame bit", {7'd0, txd}, {7'd0, e});
    end
    do_tick();
    check("R10 ready after frame", {7'd0, tx_ready}, 8'd1);
    check("R3 line idle after frame", {7'd0, txd}, 8'd1);
  endtask

  task automatic chk_par(input logic [7:0] d, input logic p, input logic [7:0] c);
    logic e;
    wr_reg(3'd3, c);
    e = c[3] && (p != exp_par(d, c));
    @(negedge clk); rx_chk = 1; rx_data = d; rx_par = p;
    @(negedge clk); rx_chk = 0;
    check("R9 parity error pulse", {7'd0, par_err}, {7'd0, e});
    @(negedge clk);
    check("R9 pulse one cycle", {7'd0, par_err}, 8'd0);
  endtask

  task automatic sel_at(input logic [2:0] a, input logic [3:0] e);
    @(negedge clk); reg_req = 1; reg_wr = 0; reg_addr = a;
    #1 check("R2 select decode", {4'd0, sel}, {4'd0, e});
    @(negedge clk); reg_req = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1550));
    repeat (3) @(negedge clk);
    reg_addr = 3'd3;
    #1 check("R1 reset value", reg_rdata, 8'h00);
    check("R3 idle high at reset", {7'd0, txd}, 8'd1);
    check("R10 ready at reset", {7'd0, tx_ready}, 8'd1);
    check("R9 no error at reset", {7'd0, par_err}, 8'd0);
    rst_ni = 1;

    wr_reg(3'd3, 8'hA5);
    reg_addr = 3'd3; #1 check("R1 readback", reg_rdata, 8'hA5);
    reg_addr = 3'd2; #1 check("R1 other offset reads zero", reg_rdata, 8'h00);
    sel_at(3'd0, 4'b0100); sel_at(3'd1, 4'b1000); sel_at(3'd3, 4'b0000);
    wr_reg(3'd3, 8'h03);
    sel_at(3'd0, 4'b0001); sel_at(3'd1, 4'b0010); sel_at(3'd2, 4'b0000);

    // directed: high bits beyond word length must not affect parity
    send(8'hE1, 8'h18, 1, 0, 0);   // 5 bits, even
    send(8'hE1, 8'h08, 1, 0, 0);   // 5 bits, odd
    send(8'h5A, 8'h3B, 1, 0, 0);   // stick 0
    send(8'h5A, 8'h2F, 1, 0, 0);   // stick 1, two stop
    send(8'h96, 8'h03, 1, 0, 0);   // no parity
    send(8'hC3, 8'h1F, 1, 1, 0);   // break mid-frame
    send(8'h3C, 8'h1A, 1, 2, 8'h2C);
    send(8'h71, 8'h2C, 0, 0, 0);   // next frame uses new format (R8)

    for (int k = 0; k < 40; k++)
      send(8'($urandom), 8'($urandom) & 8'hBF, 1, 0, 0);

    chk_par(8'hFF, 1'b1, 8'h00);   // parity off: never flagged
    chk_par(8'h1F, 1'b0, 8'h18);   // 5 ones even -> expect 1
    chk_par(8'h01, 1'b1, 8'h3B);   // stick 0
    for (int k = 0; k < 40; k++)
      chk_par(8'($urandom), 1'($urandom), 8'($urandom) & 8'h3F);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule